// File: doc/BRIEF.md
# Array and Status Write-Protection Guard

This block holds the protection fields of a serial memory's status register: a lock-enable flag and a two-bit protection level. Each request is judged against those fields, the level of the external write-protect pin and the write-enable latch, and two permits result. One says whether an array write to the presented address may go ahead. The other says whether a status-register write may go ahead. The block also builds the status byte that a read-status request returns.

A status-register write takes two steps. The data byte is taken into a pending slot when it arrives. It is copied into the stored fields on the cycle that marks the end of the serial session, and only if the write is still permitted then. While the write waits, the pin can cancel it. After the copy the pin has no effect on what was written. The fields that would survive power loss are kept as ordinary registers that reset to zero.

Top module: `prot_guard`

## Requirements
- R1: When not busy, the status byte is {lock_en, 3'b000, level[1:0], latch, 1'b0}. Bit 7 is lock_en, bits 3:2 are the level, and bit 1 is the write-enable latch.
- R2: While `busy` is 1, the status byte is 8'hFF and both permits are 0.
- R3: With a 15-bit address, the level selects the protected range as follows. Level 0 protects nothing. Level 1 protects 0x6000–0x7FFF. Level 2 protects 0x4000–0x7FFF. Level 3 protects every address.
- R4: While the latch is 0, both `arr_permit` and `stat_permit` are 0.
- R5: While the latch is 1 and the block is not busy, `arr_permit` is 1 exactly when the address is outside the protected range.
- R6: While the latch is 1 and the block is not busy, `stat_permit` is 0 only when lock_en is 1 and `pin_release` is 0. A status write with lock_en 0 succeeds even while the pin is low.
- R7: A byte given with `stw_valid` while `stat_permit` is 1 is held pending. On a cycle with `sess_end` high, a pending byte is committed if `stat_permit` is still 1. Bit 7 of the byte goes to lock_en and bits 3:2 go to the level. The new value shows on the status byte the cycle after.
- R8: If lock_en is 1 and the pin goes low while a byte is pending, the byte is dropped. It is not committed, even if the pin returns high before `sess_end`. This holds also when the pin falls in the same cycle as `sess_end`.
- R9: After a commit, a later low level on the pin leaves the stored fields unchanged.
- R10: While lock_en is 1 and the pin is low, lock_en cannot be cleared.
- R11: The stored fields change only on a commit. A `sess_end` with nothing pending changes nothing. A byte given while `stat_permit` is 0 is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the stored fields and the pending slot |
| pin_release | input | 1 | Level of the write-protect pin (1 = released, 0 = asserted) |
| wr_latch | input | 1 | Write-enable latch |
| busy | input | 1 | Internal write cycle in progress |
| chk_addr | input | ADDR_W | Array address to judge |
| stw_valid | input | 1 | Status-write data byte is present |
| stw_data | input | 8 | Status-write data byte |
| sess_end | input | 1 | End of serial session; the commit point |
| arr_permit | output | 1 | Array write to `chk_addr` is allowed |
| stat_permit | output | 1 | Status-register write is allowed |
| stat_byte | output | 8 | Status byte for a read-status request |

## Verification
Cancellation by the pin and the commit at session end can meet in one cycle. The bench provokes this by lowering the pin in the same cycle that `sess_end` is high, with a byte pending and lock_en set. The status byte read on the following cycle must still show the old fields, so the cancel wins. A second case lowers the pin one cycle before the session ends and raises it again at `sess_end`. That case shows a dropped byte is not revived.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_QTR  = 2'd1,
    LVL_HALF = 2'd2,
    LVL_ALL  = 2'd3
  } lvl_e;

  localparam int LOCK_BIT = 7;
  localparam int LVL_HI   = 3;
  localparam int LVL_LO   = 2;
  localparam int LATCH_BIT = 1;
  localparam int BUSY_BIT = 0;

  // Decide whether an address whose two top bits are top2 is in the locked range.
  function automatic logic region_locked(input lvl_e lvl, input logic [1:0] top2);
    logic hit;
    case (lvl)
      LVL_NONE: hit = 1'b0;
      LVL_QTR:  hit = (top2 == 2'b11);
      LVL_HALF: hit = top2[1];
      default:  hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] pack_status(input logic lock_en, input lvl_e lvl,
                                             input logic latch, input logic busy);
    logic [7:0] b;
    b = 8'h00;
    if (busy) begin
      b = 8'hFF;
    end else begin
      b[LOCK_BIT]      = lock_en;
      b[LVL_HI:LVL_LO] = lvl;
      b[LATCH_BIT]     = latch;
      b[BUSY_BIT]      = 1'b0;
    end
    return b;
  endfunction

endpackage

// File: rtl/prot_range.sv
module prot_range
  import prot_pkg::*;
(
  input  lvl_e       lvl,
  input  logic [1:0] top2,
  output logic       in_locked
);
  always_comb in_locked = region_locked(lvl, top2);
endmodule

// File: rtl/prot_status.sv
module prot_status
  import prot_pkg::*;
(
  input  logic       lock_en,
  input  lvl_e       lvl,
  input  logic       latch,
  input  logic       busy,
  output logic [7:0] byte_o
);
  always_comb byte_o = pack_status(lock_en, lvl, latch, busy);
endmodule

// File: rtl/prot_store.sv
module prot_store
  import prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_release,
  input  logic       stat_ok,
  input  logic       stw_valid,
  input  logic [7:0] stw_data,
  input  logic       sess_end,
  output logic       lock_en,
  output lvl_e       lvl
);
  logic       pend_q;
  logic       pend_lock_q;
  lvl_e       pend_lvl_q;
  logic       cancel_ev;
  logic       capture_ev;
  logic       commit_ev;
  logic [4:0] unused_data;

  assign unused_data = {stw_data[6:4], stw_data[1:0]};

  assign cancel_ev  = pend_q & lock_en & ~pin_release;
  assign capture_ev = stw_valid & stat_ok;
  assign commit_ev  = sess_end & pend_q & stat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_lock_q <= 1'b0;
      pend_lvl_q  <= LVL_NONE;
    end else if (sess_end || cancel_ev) begin
      pend_q <= 1'b0;
    end else if (capture_ev) begin
      pend_q      <= 1'b1;
      pend_lock_q <= stw_data[LOCK_BIT];
      pend_lvl_q  <= lvl_e'(stw_data[LVL_HI:LVL_LO]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en <= 1'b0;
      lvl     <= LVL_NONE;
    end else if (commit_ev) begin
      lock_en <= pend_lock_q;
      lvl     <= pend_lvl_q;
    end
  end

  // R8: a cancel leaves nothing pending on the next cycle
  p_cancel_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_ev |=> !pend_q);

  // R10: lock_en holds while the pin is low
  p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !pin_release) |=> lock_en);

  // R11: the stored fields move only on a session end
  p_quiet_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_end |=> ($stable(lock_en) && $stable(lvl)));

  // R7: a pending byte is only ever taken while writing is allowed
  p_pend_needs_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !stat_ok) |=> !pend_q);

endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_release,
  input  logic              wr_latch,
  input  logic              busy,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              stw_valid,
  input  logic [7:0]        stw_data,
  input  logic              sess_end,
  output logic              arr_permit,
  output logic              stat_permit,
  output logic [7:0]        stat_byte
);
  localparam int LOW_W = ADDR_W - 2;

  logic             lock_en;
  lvl_e             lvl;
  logic             in_locked;
  logic             hw_lock;
  logic             can_write;
  logic [1:0]       top2;
  logic [LOW_W-1:0] unused_low;

  assign top2       = chk_addr[ADDR_W-1 -: 2];
  assign unused_low = chk_addr[LOW_W-1:0];

  assign can_write   = wr_latch & ~busy;
  assign hw_lock     = lock_en & ~pin_release;
  assign arr_permit  = can_write & ~in_locked;
  assign stat_permit = can_write & ~hw_lock;

  prot_range u_range (
    .lvl       (lvl),
    .top2      (top2),
    .in_locked (in_locked)
  );

  prot_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_release (pin_release),
    .stat_ok     (stat_permit),
    .stw_valid   (stw_valid),
    .stw_data    (stw_data),
    .sess_end    (sess_end),
    .lock_en     (lock_en),
    .lvl         (lvl)
  );

  prot_status u_status (
    .lock_en (lock_en),
    .lvl     (lvl),
    .latch   (wr_latch),
    .busy    (busy),
    .byte_o  (stat_byte)
  );

  // R2: busy forces the all-ones byte and closes both permits
  p_busy_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stat_byte == 8'hFF && !arr_permit && !stat_permit));

  // R4: without the latch nothing may be written
  p_latch_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_latch |-> (!arr_permit && !stat_permit));

  // R6: the pin lock, seen through the status byte, refuses status writes
  p_pin_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stat_byte[LOCK_BIT] && !pin_release) |-> !stat_permit);

  // R3: the whole-array level refuses every array write
  p_all_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stat_byte[LVL_HI:LVL_LO] == 2'b11) |-> !arr_permit);

endmodule

// File: tb/sim_prot_guard.sv
module sim_prot_guard;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  lvl;
    logic        lock;
    logic        latch;
    logic        busy;
    logic        pin;
    logic [14:0] addr;
    logic        exp_arr;
    logic        exp_stat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 15'h7FFF, 1'b1, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 15'h5FFF, 1'b1, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 15'h6000, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 15'h3FFF, 1'b1, 1'b1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 15'h4000, 1'b0, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 15'h0100, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0100, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0100, 1'b1, 1'b1},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 15'h0100, 1'b1, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 15'h0000, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 15'h7FFF, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_release = 1'b1;
  logic        wr_latch = 1'b0;
  logic        busy = 1'b0;
  logic [14:0] chk_addr = '0;
  logic        stw_valid = 1'b0;
  logic [7:0]  stw_data = '0;
  logic        sess_end = 1'b0;
  logic        arr_permit, stat_permit;
  logic [7:0]  stat_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prot_guard #(.ADDR_W(15)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_release(pin_release), .wr_latch(wr_latch),
    .busy(busy), .chk_addr(chk_addr), .stw_valid(stw_valid), .stw_data(stw_data),
    .sess_end(sess_end), .arr_permit(arr_permit), .stat_permit(stat_permit),
    .stat_byte(stat_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] want_byte(input logic lock, input logic [1:0] lvl,
                                           input logic latch, input logic bz);
    if (bz) return 8'hFF;
    return {lock, 3'b000, lvl, latch, 1'b0};
  endfunction

  task automatic prog(input logic [7:0] d);
    @(negedge clk);
    pin_release = 1'b1; wr_latch = 1'b1; busy = 1'b0;
    stw_valid = 1'b1; stw_data = d;
    @(negedge clk);
    stw_valid = 1'b0; sess_end = 1'b1;
    @(negedge clk);
    sess_end = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 reset byte", stat_byte, 8'h00);
    check("R4 reset stat permit", {7'd0, stat_permit}, 8'd0);

    // table walk: R1 R3 R4 R5 R6 R2
    for (int i = 0; i < NV; i++) begin
      prog({VEC[i].lock, 3'b000, VEC[i].lvl, 2'b00});
      pin_release = VEC[i].pin; wr_latch = VEC[i].latch;
      busy = VEC[i].busy; chk_addr = VEC[i].addr;
      #1;
      check($sformatf("R3/R5 arr vec %0d", i), {7'd0, arr_permit}, {7'd0, VEC[i].exp_arr});
      check($sformatf("R6/R4 stat vec %0d", i), {7'd0, stat_permit}, {7'd0, VEC[i].exp_stat});
      check($sformatf("R1/R2 byte vec %0d", i), stat_byte,
            want_byte(VEC[i].lock, VEC[i].lvl, VEC[i].latch, VEC[i].busy));
    end

    // R6: lock_en 0, pin low, status write still lands
    prog(8'h00);
    @(negedge clk); pin_release = 1'b0; stw_valid = 1'b1; stw_data = 8'h84;
    @(negedge clk); stw_valid = 1'b0; sess_end = 1'b1;
    @(negedge clk); sess_end = 1'b0; #1;
    check("R6 write with pin low and lock off", stat_byte, 8'h86);

    // R10: lock set, pin low, clearing attempt refused
    @(negedge clk); stw_valid = 1'b1; stw_data = 8'h00;
    @(negedge clk); stw_valid = 1'b0; sess_end = 1'b1;
    @(negedge clk); sess_end = 1'b0; #1;
    check("R10 lock kept with pin low", stat_byte, 8'h86);

    // R8: pin dips while pending, back high at session end
    prog(8'h80);
    @(negedge clk); stw_valid = 1'b1; stw_data = 8'h8C;
    @(negedge clk); stw_valid = 1'b0; pin_release = 1'b0;
    @(negedge clk); pin_release = 1'b1; sess_end = 1'b1;
    @(negedge clk); sess_end = 1'b0; #1;
    check("R8 dropped after pin dip", stat_byte, 8'h82);

    // R8: pin falls in the same cycle as session end
    @(negedge clk); stw_valid = 1'b1; stw_data = 8'h8C;
    @(negedge clk); stw_valid = 1'b0; sess_end = 1'b1; pin_release = 1'b0;
    @(negedge clk); sess_end = 1'b0; pin_release = 1'b1; #1;
    check("R8 same-cycle cancel", stat_byte, 8'h82);

    // R7 / R9: commit, then pin low leaves fields alone
    prog(8'h8C);
    #1;
    check("R7 committed byte", stat_byte, 8'h8E);
    @(negedge clk); pin_release = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R9 fields after pin low", stat_byte, 8'h8E);
    check("R6 stat permit with lock and pin low", {7'd0, stat_permit}, 8'd0);

    // R10: clearing allowed once the pin is released
    prog(8'h00);
    #1;
    check("R10 cleared with pin high", stat_byte, 8'h02);

    // R11: byte offered without latch is not committed later
    @(negedge clk); wr_latch = 1'b0; stw_valid = 1'b1; stw_data = 8'h8C;
    @(negedge clk); stw_valid = 1'b0; wr_latch = 1'b1; sess_end = 1'b1;
    @(negedge clk); sess_end = 1'b0; #1;
    check("R11 unpermitted byte ignored", stat_byte, 8'h02);

    // R11: lone session end
    @(negedge clk); sess_end = 1'b1;
    @(negedge clk); sess_end = 1'b0; #1;
    check("R11 empty session end", stat_byte, 8'h02);

    // R2: busy while fields set
    prog(8'h88);
    busy = 1'b1; chk_addr = 15'h0000; #1;
    check("R2 busy byte", stat_byte, 8'hFF);
    check("R2 busy arr permit", {7'd0, arr_permit}, 8'd0);
    busy = 1'b0; #1;
    check("R1 byte after busy", stat_byte, 8'h8A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule